// File: doc/BRIEF.md
# Register-Pair Stack Transfer Sequencer

This block runs single-byte stack instructions that move a 16-bit register pair to or from a byte-wide memory stack. It holds four pairs (BC, DE, HL, and the accumulator/flags pair) and the stack pointer. A start strobe latches an 8-bit opcode. The block then steps through a fixed budget of machine cycles and T-states. It drives an address and a read or write strobe, captures or supplies the data bytes, and updates the stack pointer once at the end.

Each legal instruction takes ten clocks, one per T-state. The first four are an opcode-fetch slot with no bus activity. Two three-clock memory cycles follow. A one-clock done pulse then marks completion. An opcode that is not a pop or a push finishes after the fetch slot, raises an illegal pulse and changes nothing.

Top module: `stack_pair_seq`

## Requirements
- R1: Only two opcode forms are legal. Binary 11pp0001 is a pop and 11pp0101 is a push. Bits [5:4] (pp) select the pair: 00 BC, 01 DE, 10 HL, 11 accumulator/flags.
- R2: A pop reads the low byte at SP and the high byte at SP+1, loads the pair with {high, low} and leaves SP = SP+2.
- R3: A push writes the pair's high byte to SP-1 and then its low byte to SP-2, and leaves SP = SP-2.
- R4: Count cycles from the clock edge that accepts start_i; the cycle after that edge is k=0. In a legal instruction, addr_o holds the first address in cycles k=4..6 and the second in k=7..9. The read or write strobe is high only in k=6 and k=9. Read data is captured at the end of those cycles.
- R5: busy_o is high for cycles k=0..9 of a legal instruction. done_o is high for exactly one cycle, at k=10.
- R6: In the accumulator/flags pair the accumulator is the high byte and the flags register is the low byte. A push therefore writes the accumulator at the higher address.
- R7: SP arithmetic wraps modulo 65536. A pop with SP=FFFFh reads FFFFh and then 0000h, and a push with SP=0001h writes 0000h and then FFFFh.
- R8: start_i and opcode_i are ignored while busy_o is high.
- R9: For an illegal opcode, busy_o is high for k=0..3 with no strobe. done_o and illegal_o pulse together at k=4, and no register or SP changes.
- R10: After reset all pairs are zero, SP equals the SP_RESET parameter, and every output strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, taken when idle |
| opcode_i | input | 8 | Instruction opcode, latched with start |
| rdata_i | input | 8 | Memory read data |
| addr_o | output | 16 | Memory address |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| wdata_o | output | 8 | Memory write data |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | One-cycle illegal-opcode pulse, with done |

## Verification
The bench builds the block with SP_RESET = FFFFh and leaves the fetch and memory-cycle lengths at 4 and 3. The first pop therefore straddles the top of the address space, and the push that follows wraps back the other way. Register contents are never read directly. They come out through pushes, so a push straight after reset shows the reset values, and pushes after illegal opcodes show that nothing changed.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_POP  = 2'd1,
    OP_PUSH = 2'd2
  } op_kind_e;

  typedef enum logic [1:0] {
    PAIR_BC = 2'd0,
    PAIR_DE = 2'd1,
    PAIR_HL = 2'd2,
    PAIR_AF = 2'd3
  } pair_e;
endpackage

// File: rtl/stk_decode.sv
module stk_decode
  import stk_pkg::*;
(
  input  logic [7:0] opcode_i,
  output op_kind_e   kind_o,
  output pair_e      pair_o
);
  always_comb begin
    pair_o = pair_e'(opcode_i[5:4]);
    kind_o = OP_NONE;
    if (opcode_i[7:6] == 2'b11) begin
      unique case (opcode_i[3:0])
        4'h1:    kind_o = OP_POP;
        4'h5:    kind_o = OP_PUSH;
        default: kind_o = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/stk_timer.sv
module stk_timer #(
  parameter int FETCH_T = 4,
  parameter int MEM_T   = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       legal_i,
  output logic       busy_o,
  output logic [1:0] mem_cyc_o,
  output logic       last_t_o,
  output logic       final_o,
  output logic       done_o
);
  localparam int TOTAL = FETCH_T + 2 * MEM_T;
  localparam int CW    = $clog2(TOTAL);
  localparam logic [CW-1:0] FETCH_END  = CW'(FETCH_T - 1);
  localparam logic [CW-1:0] MEM1_START = CW'(FETCH_T);
  localparam logic [CW-1:0] MEM1_END   = CW'(FETCH_T + MEM_T - 1);
  localparam logic [CW-1:0] MEM2_START = CW'(FETCH_T + MEM_T);
  localparam logic [CW-1:0] SEQ_END    = CW'(TOTAL - 1);

  logic          busy_q, short_q, done_q;
  logic [CW-1:0] cnt_q;
  logic          final_t;

  assign final_t = busy_q && (cnt_q == (short_q ? FETCH_END : SEQ_END));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      short_q <= 1'b0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= final_t;
      if (!busy_q) begin
        if (start_i) begin
          busy_q  <= 1'b1;
          short_q <= !legal_i;
          cnt_q   <= '0;
        end
      end else if (final_t) begin
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  always_comb begin
    if (!busy_q || short_q || cnt_q < MEM1_START) mem_cyc_o = 2'd0;
    else if (cnt_q < MEM2_START)                  mem_cyc_o = 2'd1;
    else                                          mem_cyc_o = 2'd2;
  end

  assign last_t_o = busy_q && !short_q && (cnt_q == MEM1_END || cnt_q == SEQ_END);
  assign final_o  = final_t;
  assign busy_o   = busy_q;
  assign done_o   = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R5
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !final_t) |=> (busy_q && cnt_q == $past(cnt_q) + CW'(1))); // R8
  AST_DONE_AFTER_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> done_q); // R5
endmodule

// File: rtl/stk_regs.sv
module stk_regs #(
  parameter int          DATA_W   = 8,
  parameter int          ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] SP_RESET = '0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          pair_sel_i,
  input  logic                pair_we_i,
  input  logic [2*DATA_W-1:0] pair_wdata_i,
  input  logic                sp_we_i,
  input  logic [ADDR_W-1:0]   sp_wdata_i,
  output logic [2*DATA_W-1:0] pair_rdata_o,
  output logic [ADDR_W-1:0]   sp_o
);
  localparam int PW     = 2 * DATA_W;
  localparam int NPAIRS = 4;

  logic [PW-1:0]     pair_q [NPAIRS];
  logic [ADDR_W-1:0] sp_q;

  for (genvar g = 0; g < NPAIRS; g++) begin : g_pair
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   pair_q[g] <= '0;
      else if (pair_we_i && pair_sel_i == 2'(g))     pair_q[g] <= pair_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sp_q <= SP_RESET;
    else if (sp_we_i) sp_q <= sp_wdata_i;
  end

  assign pair_rdata_o = pair_q[pair_sel_i];
  assign sp_o         = sp_q;
endmodule

// File: rtl/stack_pair_seq.sv
module stack_pair_seq
  import stk_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter int          ADDR_W   = 16,
  parameter int          FETCH_T  = 4,
  parameter int          MEM_T    = 3,
  parameter logic [ADDR_W-1:0] SP_RESET = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [7:0]        opcode_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              illegal_o
);
  localparam int PW = 2 * DATA_W;

  op_kind_e kind_d, kind_q;
  pair_e    pair_d, pair_q;
  logic     busy, last_t, final_t, done;
  logic [1:0] mem_cyc;
  logic     in_mem, is_pop, is_push;
  logic [DATA_W-1:0] lo_q;
  logic     illegal_q;

  logic [PW-1:0]     pair_rd;
  logic              pair_we, sp_we;
  logic [ADDR_W-1:0] sp, sp_next, addr_mem;

  stk_decode u_decode (
    .opcode_i (opcode_i),
    .kind_o   (kind_d),
    .pair_o   (pair_d)
  );

  stk_timer #(.FETCH_T(FETCH_T), .MEM_T(MEM_T)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .legal_i   (kind_d != OP_NONE),
    .busy_o    (busy),
    .mem_cyc_o (mem_cyc),
    .last_t_o  (last_t),
    .final_o   (final_t),
    .done_o    (done)
  );

  stk_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SP_RESET(SP_RESET)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pair_sel_i   (pair_q),
    .pair_we_i    (pair_we),
    .pair_wdata_i ({rdata_i, lo_q}),
    .sp_we_i      (sp_we),
    .sp_wdata_i   (sp_next),
    .pair_rdata_o (pair_rd),
    .sp_o         (sp)
  );

  // Opcode latched only when idle; later starts are dropped.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q    <= OP_NONE;
      pair_q    <= PAIR_BC;
      lo_q      <= '0;
      illegal_q <= 1'b0;
    end else begin
      if (start_i && !busy) begin
        kind_q <= kind_d;
        pair_q <= pair_d;
      end
      if (rd_o && mem_cyc == 2'd1) lo_q <= rdata_i;
      illegal_q <= final_t && kind_q == OP_NONE;
    end
  end

  assign is_pop  = kind_q == OP_POP;
  assign is_push = kind_q == OP_PUSH;
  assign in_mem  = busy && mem_cyc != 2'd0;

  // Pop walks upward from SP, push walks downward from SP; SP moves once at the end.
  always_comb begin
    unique case ({is_push, mem_cyc == 2'd2})
      2'b00:   addr_mem = sp;
      2'b01:   addr_mem = sp + ADDR_W'(1);
      2'b10:   addr_mem = sp - ADDR_W'(1);
      default: addr_mem = sp - ADDR_W'(2);
    endcase
  end

  assign addr_o    = in_mem ? addr_mem : '0;
  assign rd_o      = in_mem && is_pop && last_t;
  assign wr_o      = in_mem && is_push && last_t;
  assign wdata_o   = (in_mem && is_push) ?
                     (mem_cyc == 2'd1 ? pair_rd[PW-1 -: DATA_W] : pair_rd[DATA_W-1:0]) : '0;
  assign pair_we   = rd_o && mem_cyc == 2'd2;
  assign sp_we     = last_t && mem_cyc == 2'd2 && (is_pop || is_push);
  assign sp_next   = is_pop ? sp + ADDR_W'(2) : sp - ADDR_W'(2);
  assign busy_o    = busy;
  assign done_o    = done;
  assign illegal_o = illegal_q;

  AST_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o)); // R4
  AST_POP_SP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && is_pop) |-> sp == $past(sp) + ADDR_W'(2)); // R2
  AST_PUSH_SP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && is_push) |-> sp == $past(sp) - ADDR_W'(2)); // R3
  AST_ILLEGAL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && kind_q == OP_NONE) |-> (!rd_o && !wr_o)); // R9
  AST_ILLEGAL_SP_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_q |-> $stable(sp)); // R9
  AST_ILLEGAL_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_q |-> done); // R9
endmodule

// File: tb/tb_stack_pair_seq.sv
module tb_stack_pair_seq;
  localparam logic [15:0] SP_INIT = 16'hFFFF;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [7:0]  rdata = 8'h00;
  logic [15:0] addr;
  logic        rd, wr, busy, done, illegal;
  logic [7:0]  wdata;

  always #5 clk = ~clk;

  stack_pair_seq #(.SP_RESET(SP_INIT)) dut (
    .clk_i (clk), .rst_ni (rst_ni), .start_i (start), .opcode_i (opcode),
    .rdata_i (rdata), .addr_o (addr), .rd_o (rd), .wr_o (wr),
    .wdata_o (wdata), .busy_o (busy), .done_o (done), .illegal_o (illegal)
  );

  typedef struct {
    bit          wr;
    logic [15:0] addr;
    logic [7:0]  data;
    int          k;
    string       req;
  } bus_item_t;

  bus_item_t   exp_q[$];
  logic [7:0]  mem [logic [15:0]];
  logic [15:0] mp [4];
  logic [15:0] msp;
  int n_checks = 0, n_fail = 0;
  int cyc = 0, t0 = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] rd_mem(logic [15:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Monitor: compares each bus strobe against the scoreboard and serves memory.
  always @(negedge clk) begin
    if (rst_ni && (rd || wr)) begin
      if (exp_q.size() == 0) begin
        check("R9", "unexpected strobe", {30'd0, rd, wr}, 32'd0);
      end else begin
        bus_item_t it;
        it = exp_q.pop_front();
        check(it.req, "strobe kind wr", {31'd0, wr}, {31'd0, it.wr});
        check(it.req, "address", {16'd0, addr}, {16'd0, it.addr});
        check("R4", "strobe cycle", cyc - t0, it.k);
        if (it.wr) check(it.req, "write data", {24'd0, wdata}, {24'd0, it.data});
      end
      if (wr) mem[addr] = wdata;
    end
    rdata <= rd_mem(addr);
  end

  task automatic run_op(input logic [7:0] op, input string req, input bit glitch = 1'b0);
    bit legal;
    int p, n;
    bit bad_busy;
    legal = op[7:6] == 2'b11 && (op[3:0] == 4'h1 || op[3:0] == 4'h5);
    p = op[5:4];
    n = legal ? 10 : 4;
    if (legal && op[3:0] == 4'h1) begin
      bus_item_t a, b;
      a = '{0, msp, rd_mem(msp), 6, req};
      b = '{0, msp + 16'd1, rd_mem(msp + 16'd1), 9, req};
      exp_q.push_back(a);
      exp_q.push_back(b);
    end else if (legal) begin
      bus_item_t a, b;
      a = '{1, msp - 16'd1, mp[p][15:8], 6, req};
      b = '{1, msp - 16'd2, mp[p][7:0], 9, req};
      exp_q.push_back(a);
      exp_q.push_back(b);
    end
    @(negedge clk);
    opcode = op;
    start  = 1'b1;
    t0     = cyc + 1;
    @(negedge clk);
    start  = 1'b0;
    opcode = 8'h00;
    bad_busy = 0;
    for (int k = 0; k < n; k++) begin
      if (busy !== 1'b1 || done !== 1'b0) bad_busy = 1;
      start = glitch && k == 2;
      @(negedge clk);
    end
    start = 1'b0;
    check("R5", "busy window", {31'd0, bad_busy}, 32'd0);
    check("R5", "done at end", {31'd0, done}, 32'd1);
    check("R5", "idle at end", {31'd0, busy}, 32'd0);
    check(legal ? "R8" : "R9", "illegal flag", {31'd0, illegal}, {31'd0, !legal});
    @(negedge clk);
    check("R5", "done single pulse", {30'd0, done, illegal}, 32'd0);
    check(req, "scoreboard drained", exp_q.size(), 0);
    if (legal && op[3:0] == 4'h1) begin
      mp[p] = {rd_mem(msp + 16'd1), rd_mem(msp)};
      msp   = msp + 16'd2;
    end else if (legal) begin
      msp   = msp - 16'd2;
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) mp[i] = 16'h0000;
    msp = SP_INIT;
    repeat (3) @(negedge clk);
    check("R10", "reset strobes", {27'd0, rd, wr, busy, done, illegal}, 32'd0);
    check("R10", "reset address", {16'd0, addr}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    mem[16'hFFFF] = 8'hBB; mem[16'h0000] = 8'hAA;
    run_op(8'hD1, "R7");          // pop DE across top of memory
    run_op(8'hD5, "R7");          // push DE wraps back down
    run_op(8'hC5, "R10");         // BC still zero from reset
    mem[16'hFFFD] = 8'h34; mem[16'hFFFE] = 8'h12;
    run_op(8'hE1, "R2");          // HL <= 1234
    mem[16'hFFFF] = 8'hD5; mem[16'h0000] = 8'hC3;
    run_op(8'hF1, "R6");          // A=C3 high, F=D5 low
    run_op(8'hF5, "R6");          // accumulator to higher address
    run_op(8'hE5, "R3");
    run_op(8'hC1, "R1");          // BC from stack
    run_op(8'hC1, "R8", 1'b1);    // start pulsed mid-sequence
    run_op(8'h00, "R9");
    run_op(8'hC3, "R9");
    run_op(8'h41, "R9");
    run_op(8'hC5, "R1");
    run_op(8'hD5, "R1");
    run_op(8'hE5, "R1");
    run_op(8'hF5, "R1");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule